// File: doc/BRIEF.md
# Flash Command Sequencer with Sector Write Guard

This block sits between a byte-wide bus master and a sectored flash array. It watches bus write cycles, decodes two-cycle unlock prefixes followed by command bytes, and starts program, sector-erase and whole-array erase operations. It keeps a per-sector write guard, tracks whether an operation is running, failed or is recovering, and selects what a bus read returns: array contents, identification bytes, the guard vector or a status byte.

The guard vector can only be loaded through a separate privileged configuration port. A software bus master can read it but cannot alter it. An abort input stops whatever is running. A return-to-read command behaves differently depending on the operation in progress: it is ignored during a program or a whole-array erase, it cancels a sector erase, and it clears a failure. After a cancelled or failed operation the block waits out a fixed recovery delay before it reports ready again. The storage array is a behavioural stub with fixed cycle-count durations.

Top module: `fcs_top`

## Requirements
- R1: A program or sector-erase command aimed at a guarded sector (guard bit set) is dropped. The array is unchanged and the mode stays read (0) with ready high. A whole-array erase skips guarded sectors and is dropped when every sector is guarded.
- R2: The guard vector changes only when `cfg_prot_we` is high. In guard-read mode, `bus_rdata` returns the vector zero-extended, with bit s holding sector s.
- R3: The return-to-read command is data F0h written in one cycle. It is accepted both bare and after the unlock prefix (AAh to address AAAh, then 55h to address 554h).
- R4: Unlock plus 90h enters identification mode (code 1). Word address bit 0 = 0 reads `MFR_ID` and bit 0 = 1 reads `DEV_ID`. Unlock plus C0h enters guard-read mode (code 2). Both modes persist through other writes until a return-to-read command.
- R5: A program that would need any bit to go from 0 to 1 ends in the error mode (code 6). In that mode `err_flag` is high, `bus_rdata` is 20h (bit 5) and the cell is unchanged. A return-to-read command clears the flag and enters recovery (code 7) for `REC_CYC` cycles, then read mode.
- R6: A return-to-read command during a program (code 3) or whole-array erase (code 5) is ignored, and the operation completes normally.
- R7: A return-to-read command during a sector erase (code 4) cancels it and leaves the sector unchanged. Recovery then lasts `REC_CYC` cycles.
- R8: An abort pulse during a program, an erase, an error or recovery enters recovery for `REC_CYC` cycles and leaves the array unchanged. In any other mode it returns to read mode on the next cycle and clears the unlock decoder.
- R9: A read of a guarded sector returns its stored data after any attempted program or erase.
- R10: A wrong address or data value in either unlock cycle returns the decoder to idle with no mode change and no array change.
- R11: Mode codes are 0 read, 1 identification, 2 guard-read, 3 program, 4 sector erase, 5 whole-array erase, 6 error, 7 recovery. `ready` is high only in codes 0 to 2. While busy, failed or recovering, every command other than return-to-read is ignored.
- R12: A program lasts `PROG_CYC` cycles and stores old AND new data. A sector erase lasts `SERASE_CYC` cycles and a whole-array erase lasts `BULK_CYC` cycles. Both set the erased words to FFh. The sector is address bits [11:10] and the word is bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; array to FFh, guard vector cleared |
| abort_pin | input | 1 | Abort request, sampled on the clock |
| bus_we | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | 12 | Bus byte address |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Read data selected by mode |
| cfg_prot_we | input | 1 | Privileged guard-vector load strobe |
| cfg_prot_val | input | NSEC | Guard vector value to load |
| ready | output | 1 | High when a command can be accepted |
| err_flag | output | 1 | High while a failed program awaits return-to-read |
| mode | output | 3 | Current mode code (see R11) |

## Verification
The bench builds the block with `PROG_CYC`=5, `SERASE_CYC`=9, `BULK_CYC`=13 and `REC_CYC`=11. The delays are kept short and distinct so that each recovery and operation window can be counted edge by edge within a few hundred cycles. A return-to-read or abort landing mid-operation is then clearly inside the window and not at its last cycle. The default of 2500 recovery cycles (25 µs at 100 MHz) uses the same counter and only changes the count.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] UNLK_A1 = 12'hAAA;
    localparam logic [ADDR_W-1:0] UNLK_A2 = 12'h554;
    localparam logic [7:0]        UNLK_D1 = 8'hAA;
    localparam logic [7:0]        UNLK_D2 = 8'h55;

    localparam logic [7:0] OPC_TO_READ = 8'hF0;
    localparam logic [7:0] OPC_PROG    = 8'hA0;
    localparam logic [7:0] OPC_ERASE   = 8'h80;
    localparam logic [7:0] OPC_IDENT   = 8'h90;
    localparam logic [7:0] OPC_GUARD   = 8'hC0;
    localparam logic [7:0] ERS_SECTOR  = 8'h30;
    localparam logic [7:0] ERS_ALL     = 8'h10;

    typedef enum logic [2:0] {
        MD_READ    = 3'd0,
        MD_IDENT   = 3'd1,
        MD_GUARD   = 3'd2,
        MD_PROG    = 3'd3,
        MD_SERASE  = 3'd4,
        MD_BULK    = 3'd5,
        MD_ERROR   = 3'd6,
        MD_RECOVER = 3'd7
    } fcs_mode_e;

    typedef enum logic [2:0] {
        CK_NONE, CK_TO_READ, CK_PROG, CK_SERASE, CK_BULK, CK_IDENT, CK_GUARD
    } fcs_cmd_e;

    typedef struct packed {
        fcs_cmd_e    kind;
        logic [7:0]  data;
    } fcs_cmd_t;

    typedef struct packed {
        logic       ready;
        logic       err;
        fcs_mode_e  mode;
    } fcs_stat_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic in_operation(input fcs_mode_e m);
        return m inside {MD_PROG, MD_SERASE, MD_BULK, MD_ERROR, MD_RECOVER};
    endfunction

endpackage

// File: rtl/fcs_cmd_decode.sv
module fcs_cmd_decode
    import fcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output fcs_cmd_t          cmd
);

    typedef enum logic [2:0] {DS_IDLE, DS_UNLK1, DS_UNLK2, DS_PSETUP, DS_ESETUP} dec_state_e;

    dec_state_e st_q, st_d;

    always_comb begin
        st_d      = st_q;
        cmd.kind  = CK_NONE;
        cmd.data  = wdata;
        if (we) begin
            case (st_q)
                DS_IDLE: begin
                    if (addr == UNLK_A1 && wdata == UNLK_D1) st_d = DS_UNLK1;
                    else if (wdata == OPC_TO_READ)           cmd.kind = CK_TO_READ;
                end
                DS_UNLK1: st_d = (addr == UNLK_A2 && wdata == UNLK_D2) ? DS_UNLK2 : DS_IDLE;
                DS_UNLK2: begin
                    st_d = DS_IDLE;
                    case (wdata)
                        OPC_TO_READ: cmd.kind = CK_TO_READ;
                        OPC_PROG:    st_d = DS_PSETUP;
                        OPC_ERASE:   st_d = DS_ESETUP;
                        OPC_IDENT:   cmd.kind = CK_IDENT;
                        OPC_GUARD:   cmd.kind = CK_GUARD;
                        default:     st_d = DS_IDLE;
                    endcase
                end
                DS_PSETUP: begin
                    st_d     = DS_IDLE;
                    cmd.kind = CK_PROG;
                end
                DS_ESETUP: begin
                    st_d = DS_IDLE;
                    if (wdata == ERS_SECTOR)   cmd.kind = CK_SERASE;
                    else if (wdata == ERS_ALL) cmd.kind = CK_BULK;
                end
                default: st_d = DS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) st_q <= DS_IDLE;
        else              st_q <= st_d;
    end

endmodule

// File: rtl/fcs_op_ctrl.sv
module fcs_op_ctrl
    import fcs_pkg::*;
#(
    parameter int NSEC       = 4,
    parameter int WBITS      = 2,
    parameter int PROG_CYC   = 8,
    parameter int SERASE_CYC = 40,
    parameter int BULK_CYC   = 80,
    parameter int REC_CYC    = 2500,
    localparam int SEC_BITS  = $clog2(NSEC),
    localparam int IDX_W     = SEC_BITS + WBITS
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                abort,
    input  fcs_cmd_t            cmd,
    input  logic [SEC_BITS-1:0] cmd_sec,
    input  logic [WBITS-1:0]    cmd_word,
    input  logic [NSEC-1:0]     prot,
    input  logic [7:0]          cell_data,
    output logic [IDX_W-1:0]    op_idx,
    output logic                wr_en,
    output logic [7:0]          wr_data,
    output logic [NSEC-1:0]     ers_mask,
    output fcs_stat_t           stat
);

    localparam int MAX_CYC = imax(imax(PROG_CYC, SERASE_CYC), imax(BULK_CYC, REC_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    fcs_mode_e          mode_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [IDX_W-1:0]   idx_q;
    logic [7:0]         data_q;
    logic [NSEC-1:0]    mask_q;
    logic               last_cyc, fail, to_read;

    assign last_cyc = (cnt_q == '0);
    assign fail     = |(data_q & ~cell_data);
    assign to_read  = (cmd.kind == CK_TO_READ);

    assign op_idx   = idx_q;
    assign wr_data  = data_q;
    assign wr_en    = (mode_q == MD_PROG) && last_cyc && !abort && !fail;
    assign ers_mask = ((mode_q == MD_BULK || (mode_q == MD_SERASE && !to_read))
                       && last_cyc && !abort) ? mask_q : '0;

    assign stat.mode  = mode_q;
    assign stat.err   = (mode_q == MD_ERROR);
    assign stat.ready = (mode_q inside {MD_READ, MD_IDENT, MD_GUARD});

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MD_READ;
            cnt_q  <= '0;
            idx_q  <= '0;
            data_q <= '0;
            mask_q <= '0;
        end else if (abort) begin
            if (in_operation(mode_q)) begin
                mode_q <= MD_RECOVER;
                cnt_q  <= CNT_W'(REC_CYC - 1);
            end else begin
                mode_q <= MD_READ;
            end
        end else begin
            case (mode_q)
                MD_READ: begin
                    case (cmd.kind)
                        CK_PROG: if (!prot[cmd_sec]) begin
                            mode_q <= MD_PROG;
                            cnt_q  <= CNT_W'(PROG_CYC - 1);
                            idx_q  <= {cmd_sec, cmd_word};
                            data_q <= cmd.data;
                        end
                        CK_SERASE: if (!prot[cmd_sec]) begin
                            mode_q <= MD_SERASE;
                            cnt_q  <= CNT_W'(SERASE_CYC - 1);
                            mask_q <= NSEC'(1) << cmd_sec;
                        end
                        CK_BULK: if (|(~prot)) begin
                            mode_q <= MD_BULK;
                            cnt_q  <= CNT_W'(BULK_CYC - 1);
                            mask_q <= ~prot;
                        end
                        CK_IDENT: mode_q <= MD_IDENT;
                        CK_GUARD: mode_q <= MD_GUARD;
                        default:  mode_q <= MD_READ;
                    endcase
                end
                MD_IDENT, MD_GUARD: if (to_read) mode_q <= MD_READ;
                MD_PROG: begin
                    if (last_cyc) mode_q <= fail ? MD_ERROR : MD_READ;
                    else          cnt_q  <= cnt_q - 1'b1;
                end
                MD_SERASE: begin
                    if (to_read) begin
                        mode_q <= MD_RECOVER;
                        cnt_q  <= CNT_W'(REC_CYC - 1);
                    end else if (last_cyc) mode_q <= MD_READ;
                    else                   cnt_q  <= cnt_q - 1'b1;
                end
                MD_BULK, MD_RECOVER: begin
                    if (last_cyc) mode_q <= MD_READ;
                    else          cnt_q  <= cnt_q - 1'b1;
                end
                MD_ERROR: if (to_read) begin
                    mode_q <= MD_RECOVER;
                    cnt_q  <= CNT_W'(REC_CYC - 1);
                end
                default: mode_q <= MD_READ;
            endcase
        end
    end

endmodule

// File: rtl/fcs_array.sv
module fcs_array
    import fcs_pkg::*;
#(
    parameter int          NSEC   = 4,
    parameter int          WBITS  = 2,
    parameter logic [7:0]  MFR_ID = 8'h5E,
    parameter logic [7:0]  DEV_ID = 8'hA7,
    localparam int SEC_BITS = $clog2(NSEC),
    localparam int IDX_W    = SEC_BITS + WBITS,
    localparam int WORDS    = 1 << WBITS,
    localparam int DEPTH    = NSEC * WORDS
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] op_idx,
    input  logic [7:0]       wr_data,
    input  logic [NSEC-1:0]  ers_mask,
    output logic [7:0]       cell_data,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             rd_lsb,
    input  fcs_mode_e        mode,
    input  logic [NSEC-1:0]  prot,
    output logic [7:0]       rdata
);

    logic [7:0] flat [DEPTH];

    for (genvar s = 0; s < NSEC; s++) begin : g_sec
        logic [7:0] cell_q [WORDS];
        logic       hit;
        assign hit = wr_en && (op_idx[IDX_W-1 -: SEC_BITS] == SEC_BITS'(s));

        always_ff @(posedge clk) begin
            if (rst || ers_mask[s]) begin
                for (int w = 0; w < WORDS; w++) cell_q[w] <= 8'hFF;
            end else if (hit) begin
                cell_q[op_idx[WBITS-1:0]] <= cell_q[op_idx[WBITS-1:0]] & wr_data;
            end
        end

        for (genvar w = 0; w < WORDS; w++) begin : g_word
            assign flat[s*WORDS + w] = cell_q[w];
        end
    end

    assign cell_data = flat[op_idx];

    always_comb begin
        case (mode)
            MD_READ:  rdata = flat[rd_idx];
            MD_IDENT: rdata = rd_lsb ? DEV_ID : MFR_ID;
            MD_GUARD: rdata = 8'(prot);
            MD_ERROR: rdata = 8'h20;
            default:  rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/fcs_top.sv
module fcs_top
    import fcs_pkg::*;
#(
    parameter int          NSEC       = 4,
    parameter int          WBITS      = 2,
    parameter int          PROG_CYC   = 8,
    parameter int          SERASE_CYC = 40,
    parameter int          BULK_CYC   = 80,
    parameter int          REC_CYC    = 2500,
    parameter logic [7:0]  MFR_ID     = 8'h5E,
    parameter logic [7:0]  DEV_ID     = 8'hA7
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             abort_pin,
    input  logic             bus_we,
    input  logic [11:0]      bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic             cfg_prot_we,
    input  logic [NSEC-1:0]  cfg_prot_val,
    output logic             ready,
    output logic             err_flag,
    output logic [2:0]       mode
);

    localparam int SEC_BITS = $clog2(NSEC);
    localparam int IDX_W    = SEC_BITS + WBITS;

    fcs_cmd_t            dec_cmd;
    fcs_stat_t           stat;
    logic [NSEC-1:0]     prot_q;
    logic [SEC_BITS-1:0] cmd_sec;
    logic [WBITS-1:0]    cmd_word;
    logic [IDX_W-1:0]    op_idx;
    logic                wr_en;
    logic [7:0]          wr_data, cell_data;
    logic [NSEC-1:0]     ers_mask;
    fcs_mode_e           op_mode;

    assign cmd_sec  = bus_addr[ADDR_W-1 -: SEC_BITS];
    assign cmd_word = bus_addr[WBITS-1:0];
    assign op_mode  = stat.mode;

    always_ff @(posedge clk) begin
        if (rst)              prot_q <= '0;
        else if (cfg_prot_we) prot_q <= cfg_prot_val;
    end

    fcs_cmd_decode u_dec (
        .clk(clk), .rst(rst), .flush(abort_pin), .we(bus_we),
        .addr(bus_addr), .wdata(bus_wdata), .cmd(dec_cmd)
    );

    fcs_op_ctrl #(
        .NSEC(NSEC), .WBITS(WBITS), .PROG_CYC(PROG_CYC), .SERASE_CYC(SERASE_CYC),
        .BULK_CYC(BULK_CYC), .REC_CYC(REC_CYC)
    ) u_ctrl (
        .clk(clk), .rst(rst), .abort(abort_pin), .cmd(dec_cmd),
        .cmd_sec(cmd_sec), .cmd_word(cmd_word), .prot(prot_q), .cell_data(cell_data),
        .op_idx(op_idx), .wr_en(wr_en), .wr_data(wr_data), .ers_mask(ers_mask), .stat(stat)
    );

    fcs_array #(
        .NSEC(NSEC), .WBITS(WBITS), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
    ) u_arr (
        .clk(clk), .rst(rst), .wr_en(wr_en), .op_idx(op_idx), .wr_data(wr_data),
        .ers_mask(ers_mask), .cell_data(cell_data), .rd_idx({cmd_sec, cmd_word}),
        .rd_lsb(bus_addr[0]), .mode(op_mode), .prot(prot_q), .rdata(bus_rdata)
    );

    assign ready    = stat.ready;
    assign err_flag = stat.err;
    assign mode     = 3'(stat.mode);

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker
    import fcs_pkg::*;
#(
    parameter int NSEC     = 4,
    parameter int SEC_BITS = 2
)(
    input logic                clk,
    input logic                rst,
    input logic                abort_pin,
    input logic                cfg_prot_we,
    input logic                err_flag,
    input fcs_mode_e           mode,
    input fcs_cmd_e            cmd_kind,
    input logic [SEC_BITS-1:0] cmd_sec,
    input logic [NSEC-1:0]     prot
);

    AST_GUARD_DROPS: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_READ && !abort_pin && (cmd_kind == CK_PROG || cmd_kind == CK_SERASE)
         && prot[cmd_sec]) |=> (mode == MD_READ)); // R1

    AST_GUARD_BUS_RO: assert property (@(posedge clk) disable iff (rst)
        !cfg_prot_we |=> $stable(prot)); // R2

    AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_ERROR && cmd_kind == CK_TO_READ && !abort_pin)
        |=> (mode == MD_RECOVER && !err_flag)); // R5

    AST_ERR_FROM_PROG: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> ($past(mode) == MD_PROG)); // R5

    AST_TO_READ_IGNORED: assert property (@(posedge clk) disable iff (rst)
        ((mode == MD_PROG || mode == MD_BULK) && cmd_kind == CK_TO_READ && !abort_pin)
        |=> (mode != MD_RECOVER)); // R6

    AST_SERASE_CANCEL: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_SERASE && cmd_kind == CK_TO_READ && !abort_pin)
        |=> (mode == MD_RECOVER)); // R7

    AST_ABORT_SAFE: assert property (@(posedge clk) disable iff (rst)
        abort_pin |=> (mode == MD_READ || mode == MD_RECOVER)); // R8

    AST_RECOVER_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_RECOVER && !abort_pin) |=> (mode == MD_RECOVER || mode == MD_READ)); // R11

endmodule

bind fcs_top fcs_checker #(.NSEC(NSEC), .SEC_BITS(SEC_BITS)) u_chk (
    .clk(clk), .rst(rst), .abort_pin(abort_pin), .cfg_prot_we(cfg_prot_we),
    .err_flag(err_flag), .mode(op_mode), .cmd_kind(dec_cmd.kind),
    .cmd_sec(cmd_sec), .prot(prot_q)
);

// File: tb/fcs_top_tb_top.sv
module fcs_top_tb_top;

    localparam int NSEC = 4, PROG = 5, SERASE = 9, BULK = 13, REC = 11;
    localparam int MFR = 8'h5E, DEV = 8'hA7;

    logic clk = 1'b0, rst = 1'b1, abort_pin = 1'b0, bus_we = 1'b0, cfg_prot_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0, bus_rdata;
    logic [NSEC-1:0] cfg_prot_val = '0;
    logic ready, err_flag;
    logic [2:0] mode;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fcs_top #(.NSEC(NSEC), .WBITS(2), .PROG_CYC(PROG), .SERASE_CYC(SERASE),
              .BULK_CYC(BULK), .REC_CYC(REC)) dut_i (
        .clk(clk), .rst(rst), .abort_pin(abort_pin), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_prot_we(cfg_prot_we),
        .cfg_prot_val(cfg_prot_val), .ready(ready), .err_flag(err_flag), .mode(mode)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_mode = 0, m_left = 0, m_step = 0, m_idx = 0, m_data = 0, m_mask = 0, m_prot = 0;
    int m_mem [NSEC*4];

    function automatic int exp_rdata();
        case (m_mode)
            0: return m_mem[(bus_addr >> 10) * 4 + (bus_addr & 3)];
            1: return bus_addr[0] ? DEV : MFR;
            2: return m_prot;
            6: return 8'h20;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        int cmd, sec;
        cmd = 0;
        sec = bus_addr >> 10;
        if (rst) begin
            m_mode = 0; m_left = 0; m_step = 0; m_prot = 0;
            foreach (m_mem[i]) m_mem[i] = 8'hFF;
        end else begin
            if (abort_pin) begin
                if (m_mode >= 3) begin m_mode = 7; m_left = REC; end
                else m_mode = 0;
                m_step = 0;
            end else begin
                if (bus_we) begin
                    if (m_step == 0) begin
                        if (bus_addr == 12'hAAA && bus_wdata == 8'hAA) m_step = 1;
                        else if (bus_wdata == 8'hF0) cmd = 1;
                    end else if (m_step == 1) begin
                        m_step = (bus_addr == 12'h554 && bus_wdata == 8'h55) ? 2 : 0;
                    end else if (m_step == 2) begin
                        m_step = 0;
                        if (bus_wdata == 8'hF0) cmd = 1;
                        else if (bus_wdata == 8'hA0) m_step = 3;
                        else if (bus_wdata == 8'h80) m_step = 4;
                        else if (bus_wdata == 8'h90) cmd = 5;
                        else if (bus_wdata == 8'hC0) cmd = 6;
                    end else if (m_step == 3) begin
                        m_step = 0; cmd = 2;
                    end else begin
                        m_step = 0;
                        if (bus_wdata == 8'h30) cmd = 3;
                        else if (bus_wdata == 8'h10) cmd = 4;
                    end
                end
                case (m_mode)
                    0: begin
                        if (cmd == 2 && !m_prot[sec]) begin
                            m_mode = 3; m_left = PROG;
                            m_idx = sec * 4 + (bus_addr & 3); m_data = bus_wdata;
                        end else if (cmd == 3 && !m_prot[sec]) begin
                            m_mode = 4; m_left = SERASE; m_mask = 1 << sec;
                        end else if (cmd == 4 && ((~m_prot) & 15) != 0) begin
                            m_mode = 5; m_left = BULK; m_mask = (~m_prot) & 15;
                        end else if (cmd == 5) m_mode = 1;
                        else if (cmd == 6) m_mode = 2;
                    end
                    1, 2: if (cmd == 1) m_mode = 0;
                    3: begin
                        m_left--;
                        if (m_left == 0) begin
                            if ((m_data & ~m_mem[m_idx] & 8'hFF) != 0) m_mode = 6;
                            else begin m_mem[m_idx] = m_mem[m_idx] & m_data; m_mode = 0; end
                        end
                    end
                    4, 5: begin
                        if (m_mode == 4 && cmd == 1) begin m_mode = 7; m_left = REC; end
                        else begin
                            m_left--;
                            if (m_left == 0) begin
                                for (int s = 0; s < NSEC; s++)
                                    if (m_mask[s]) for (int w = 0; w < 4; w++) m_mem[s*4+w] = 8'hFF;
                                m_mode = 0;
                            end
                        end
                    end
                    6: if (cmd == 1) begin m_mode = 7; m_left = REC; end
                    default: begin m_left--; if (m_left == 0) m_mode = 0; end
                endcase
            end
            if (cfg_prot_we) m_prot = cfg_prot_val;
        end
    end

    always @(posedge clk) begin
        #3;
        if (!rst && !done) begin
            chk("R11 mode vs model", mode, m_mode);
            chk("R11 ready vs model", ready, m_mode <= 2);
            chk("R5 err_flag vs model", err_flag, m_mode == 6);
            chk("R9 rdata vs model", bus_rdata, exp_rdata());
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic unlock();
        wr(12'hAAA, 8'hAA); wr(12'h554, 8'h55);
    endtask

    task automatic prog(input logic [11:0] a, input logic [7:0] d);
        unlock(); wr(12'hAAA, 8'hA0); wr(a, d);
    endtask

    task automatic erase_cmd(input logic [11:0] a, input logic [7:0] kind);
        unlock(); wr(12'hAAA, 8'h80); wr(a, kind);
    endtask

    task automatic pulse_abort();
        abort_pin = 1'b1; @(negedge clk); abort_pin = 1'b0;
    endtask

    task automatic set_guard(input logic [NSEC-1:0] v);
        cfg_prot_we = 1'b1; cfg_prot_val = v; @(negedge clk); cfg_prot_we = 1'b0;
    endtask

    task automatic count_mode(input int m, output int n);
        n = 0;
        while (mode == 3'(m) && n < 5000) begin n++; @(negedge clk); end
    endtask

    task automatic rd(input logic [11:0] a, input int exp, input string tag);
        bus_addr = a; #1;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog R11 actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("reset mode R11", mode, 0);
        chk("reset ready R11", ready, 1);
        chk("reset err R5", err_flag, 0);

        prog(12'h400, 8'h33); count_mode(3, n);
        chk("R12 program length", n, PROG);
        set_guard(4'b0010);

        unlock(); wr(12'hAAA, 8'hC0);
        chk("R4 guard-read mode", mode, 2);
        rd(12'h000, 8'h02, "R2 guard vector read");
        wr(12'h000, 8'h00);
        chk("R4 guard-read persists", mode, 2);
        wr(12'h000, 8'hF0);
        chk("R3 bare return-to-read", mode, 0);

        prog(12'h001, 8'h5A);
        chk("R11 ready low while busy", ready, 0);
        count_mode(3, n);
        chk("R12 program length again", n + 1, PROG + 1);
        rd(12'h001, 8'h5A, "R12 programmed value");

        prog(12'h400, 8'h00);
        chk("R1 guarded program dropped", mode, 0);
        rd(12'h400, 8'h33, "R9 guarded sector verify");
        erase_cmd(12'h400, 8'h30);
        chk("R1 guarded erase dropped", mode, 0);
        chk("R1 ready stays high", ready, 1);

        prog(12'h001, 8'hFF); count_mode(3, n);
        chk("R5 error mode", mode, 6);
        chk("R5 error flag", err_flag, 1);
        rd(12'h001, 8'h20, "R5 status bit 5");
        prog(12'h002, 8'h00);
        chk("R11 writes ignored in error", mode, 6);
        wr(12'h000, 8'hF0);
        chk("R5 flag cleared", err_flag, 0);
        count_mode(7, n);
        chk("R5 recovery length", n, REC);
        rd(12'h001, 8'h5A, "R5 failed cell unchanged");
        rd(12'h002, 8'hFF, "R11 ignored program no effect");

        unlock(); wr(12'hAAA, 8'h90);
        chk("R4 identification mode", mode, 1);
        rd(12'h000, MFR, "R4 maker byte");
        rd(12'h001, DEV, "R4 device byte");
        unlock(); wr(12'hAAA, 8'hF0);
        chk("R3 prefixed return-to-read", mode, 0);

        wr(12'hAAA, 8'hAA); wr(12'h555, 8'h55); wr(12'hAAA, 8'hA0); wr(12'h002, 8'h00);
        @(negedge clk);
        chk("R10 bad second address", mode, 0);
        rd(12'h002, 8'hFF, "R10 no array change");
        wr(12'hAAA, 8'hAB); wr(12'h554, 8'h55); wr(12'hAAA, 8'h90);
        chk("R10 bad first data", mode, 0);

        prog(12'h002, 8'h0F); wr(12'h000, 8'hF0);
        chk("R6 reset ignored in program", mode, 3);
        count_mode(3, n);
        rd(12'h002, 8'h0F, "R6 program completed");

        prog(12'h003, 8'h11); count_mode(3, n);
        erase_cmd(12'h000, 8'h30);
        @(negedge clk); @(negedge clk);
        wr(12'h000, 8'hF0);
        chk("R7 sector erase cancelled", mode, 7);
        count_mode(7, n);
        chk("R7 recovery length", n, REC);
        rd(12'h003, 8'h11, "R7 sector unchanged");

        erase_cmd(12'hAAA, 8'h10); wr(12'h000, 8'hF0);
        chk("R6 reset ignored in whole erase", mode, 5);
        count_mode(5, n);
        chk("R12 whole erase length", n + 1, BULK);
        rd(12'h003, 8'hFF, "R12 erased word");
        rd(12'h001, 8'hFF, "R12 erased word 2");
        rd(12'h400, 8'h33, "R1 guarded sector kept");

        prog(12'h800, 8'h44); pulse_abort();
        chk("R8 abort enters recovery", mode, 7);
        unlock(); wr(12'hAAA, 8'h90);
        count_mode(7, n);
        chk("R8 abort recovery length", n + 3, REC);
        chk("R11 ident ignored in recovery", mode, 0);
        rd(12'h800, 8'hFF, "R8 aborted program no effect");

        unlock(); wr(12'hAAA, 8'h90); pulse_abort();
        chk("R8 abort from ident", mode, 0);

        set_guard(4'b0000);
        prog(12'h400, 8'h30); count_mode(3, n);
        rd(12'h400, 8'h30, "R2 unguarded via config port");

        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule